// File: doc/BRIEF.md
# Integer Decode and Execute Stage

This block takes one 32-bit instruction word and the two source register values that a register file has already read for it, and returns the value to be written back, the register number it goes to and a write-enable. It decodes the fixed three-register layout and the register-plus-16-bit-constant layout, chooses the second operand (register, shift count or widened constant) and runs one integer operation.

The supported operations are add, bitwise AND, OR and NOR, logical left and right shift, add-with-constant, AND/OR with a constant, signed set-on-less-than against a constant, and load of a constant into the upper half. Each constant form widens its 16-bit field in its own way: by copying its sign bit, by padding with zeros, or by moving it to the top half.

The result is registered. The outputs show the outcome of the word presented one clock edge earlier. The block sits between a register read stage and a write-back stage in a larger core.

Top module: `exec_stage`

## Requirements
- R1: The outputs `result_o`, `dst_o` and `wr_en_o` are registered. They show the outcome of the inputs sampled at the previous rising clock edge. While `rst_n` is low, all three outputs are zero.
- R2: Field layout: opcode is bits 31:26, first source index bits 25:21, second source index bits 20:16, three-register destination bits 15:11, shift count bits 10:6, function code bits 5:0, and constant bits 15:0. Opcode 0 with function 32 adds the two source values modulo 2^32.
- R3: Opcode 0 with function 36, 37 or 39 gives the bitwise AND, OR, or inverted OR of the two source values. An inverted OR whose second source index is 0 gives the bitwise NOT of the first source.
- R4: Opcode 0 with function 0 shifts the second source value left by the shift count. Opcode 0 with function 2 shifts it right by the shift count. The count ranges from 0 to 31, and vacated bits are zero in both directions.
- R5: Opcode 0x08 adds the constant, sign-extended from bit 15, to the first source value.
- R6: Opcode 0x0C (AND) and opcode 0x0D (OR) combine the first source value with the constant zero-extended to 32 bits.
- R7: Opcode 0x0A gives 1 when the first source value is less than the sign-extended constant, both taken as two's-complement, and 0 otherwise.
- R8: Opcode 0x0F places the constant in result bits 31:16 and zeros in bits 15:0.
- R9: A source index of 0 in either source field supplies the value 0, whatever the matching input value is.
- R10: The destination is bits 15:11 for opcode 0 and bits 20:16 for the constant forms. `wr_en_o` is low whenever the destination is register 0.
- R11: An unsupported opcode, or opcode 0 with an unsupported function code, gives `result_o` = 0, `dst_o` = 0 and `wr_en_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | 32 | Instruction word |
| rs_val_i | input | 32 | Value read for the first source index |
| rt_val_i | input | 32 | Value read for the second source index |
| result_o | output | 32 | Registered write-back value |
| dst_o | output | 5 | Registered destination register number |
| wr_en_o | output | 1 | Registered write-enable |

## Verification
The bench targets the ways a constant can be widened wrongly: a 0x8000-class constant that is zero-extended instead of sign-extended gives a large positive sum, and a logic constant that is sign-extended sets the upper 16 bits. It applies shift counts of 0 and 31 and set-on-less-than operands at the signed extremes. An unsigned comparison would report 0x80000000 as larger than 0x7FFF, and a wrong shift fill would leave ones in the vacated bits. It feeds nonzero values on register-0 source fields, because a missing mask leaks those values into the result. It also uses a zero destination and unknown codes, where a wrong design would still raise the write-enable or let the adder output reach `result_o`.

// File: rtl/exec_pkg.sv
package exec_pkg;

    localparam int WORD_W  = 32;
    localparam int REG_AW  = 5;
    localparam int OP_W    = 6;
    localparam int FN_W    = 6;
    localparam int IMM_W   = 16;
    localparam int SH_W    = $clog2(WORD_W);
    localparam int HALF_W  = WORD_W - IMM_W;

    // Field positions inside the instruction word.
    localparam int OP_LSB  = WORD_W - OP_W;
    localparam int RS_LSB  = OP_LSB - REG_AW;
    localparam int RT_LSB  = RS_LSB - REG_AW;
    localparam int RD_LSB  = RT_LSB - REG_AW;
    localparam int SH_LSB  = RD_LSB - SH_W;

    // Opcodes.
    localparam logic [OP_W-1:0] OPC_REG      = 6'h00;
    localparam logic [OP_W-1:0] OPC_ADD_K    = 6'h08;
    localparam logic [OP_W-1:0] OPC_LESS_K   = 6'h0A;
    localparam logic [OP_W-1:0] OPC_AND_K    = 6'h0C;
    localparam logic [OP_W-1:0] OPC_OR_K     = 6'h0D;
    localparam logic [OP_W-1:0] OPC_HIGH_K   = 6'h0F;

    // Function codes under OPC_REG.
    localparam logic [FN_W-1:0] FN_SHL = 6'd0;
    localparam logic [FN_W-1:0] FN_SHR = 6'd2;
    localparam logic [FN_W-1:0] FN_ADD = 6'd32;
    localparam logic [FN_W-1:0] FN_AND = 6'd36;
    localparam logic [FN_W-1:0] FN_OR  = 6'd37;
    localparam logic [FN_W-1:0] FN_NOR = 6'd39;

    typedef enum logic [3:0] {
        ALU_NONE,
        ALU_ADD,
        ALU_AND,
        ALU_OR,
        ALU_NOR,
        ALU_SHL,
        ALU_SHR,
        ALU_LESS,
        ALU_HIGH
    } alu_op_e;

    typedef enum logic [1:0] {
        WIDEN_SIGN,
        WIDEN_ZERO,
        WIDEN_UPPER
    } widen_e;

    typedef enum logic {
        SRC_B_REG,
        SRC_B_CONST
    } src_b_e;

    typedef struct packed {
        logic    legal;
        alu_op_e op;
        src_b_e  src_b;
        widen_e  widen;
        logic    dst_from_rd;
    } ctrl_t;

    typedef struct packed {
        logic [WORD_W-1:0] result;
        logic [REG_AW-1:0] dst;
        logic              wr_en;
    } stage_t;

endpackage

// File: rtl/exec_decode.sv
module exec_decode
    import exec_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    input  logic [FN_W-1:0] fn_i,
    output ctrl_t           ctrl_o
);

    always_comb begin
        ctrl_o.legal       = 1'b1;
        ctrl_o.op          = ALU_NONE;
        ctrl_o.src_b       = SRC_B_CONST;
        ctrl_o.widen       = WIDEN_SIGN;
        ctrl_o.dst_from_rd = 1'b0;

        unique case (op_i)
            OPC_REG: begin
                ctrl_o.src_b       = SRC_B_REG;
                ctrl_o.dst_from_rd = 1'b1;
                unique case (fn_i)
                    FN_ADD:  ctrl_o.op = ALU_ADD;
                    FN_AND:  ctrl_o.op = ALU_AND;
                    FN_OR:   ctrl_o.op = ALU_OR;
                    FN_NOR:  ctrl_o.op = ALU_NOR;
                    FN_SHL:  ctrl_o.op = ALU_SHL;
                    FN_SHR:  ctrl_o.op = ALU_SHR;
                    default: ctrl_o.legal = 1'b0;
                endcase
            end
            OPC_ADD_K: begin
                ctrl_o.op    = ALU_ADD;
                ctrl_o.widen = WIDEN_SIGN;
            end
            OPC_LESS_K: begin
                ctrl_o.op    = ALU_LESS;
                ctrl_o.widen = WIDEN_SIGN;
            end
            OPC_AND_K: begin
                ctrl_o.op    = ALU_AND;
                ctrl_o.widen = WIDEN_ZERO;
            end
            OPC_OR_K: begin
                ctrl_o.op    = ALU_OR;
                ctrl_o.widen = WIDEN_ZERO;
            end
            OPC_HIGH_K: begin
                ctrl_o.op    = ALU_HIGH;
                ctrl_o.widen = WIDEN_UPPER;
            end
            default: ctrl_o.legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/exec_operand.sv
module exec_operand
    import exec_pkg::*;
#(
    parameter int N_SRC = 2
) (
    input  logic [REG_AW-1:0] idx_i [N_SRC],
    input  logic [WORD_W-1:0] val_i [N_SRC],
    input  logic [IMM_W-1:0]  imm_i,
    input  ctrl_t             ctrl_i,
    output logic [WORD_W-1:0] a_o,
    output logic [WORD_W-1:0] b_o,
    output logic [WORD_W-1:0] rt_o
);

    logic [WORD_W-1:0] src_q0 [N_SRC];
    logic [WORD_W-1:0] widened;

    // Register 0 always reads as zero on every source port.
    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        assign src_q0[g] = (idx_i[g] == '0) ? '0 : val_i[g];
    end

    always_comb begin
        unique case (ctrl_i.widen)
            WIDEN_SIGN:  widened = {{HALF_W{imm_i[IMM_W-1]}}, imm_i};
            WIDEN_ZERO:  widened = {{HALF_W{1'b0}}, imm_i};
            WIDEN_UPPER: widened = {imm_i, {HALF_W{1'b0}}};
            default:     widened = '0;
        endcase
    end

    assign a_o  = src_q0[0];
    assign rt_o = src_q0[1];
    assign b_o  = (ctrl_i.src_b == SRC_B_REG) ? src_q0[1] : widened;

endmodule

// File: rtl/exec_alu.sv
module exec_alu
    import exec_pkg::*;
(
    input  alu_op_e           op_i,
    input  logic [WORD_W-1:0] a_i,
    input  logic [WORD_W-1:0] b_i,
    input  logic [SH_W-1:0]   sh_i,
    output logic [WORD_W-1:0] y_o
);

    logic less;

    assign less = $signed(a_i) < $signed(b_i);

    always_comb begin
        unique case (op_i)
            ALU_ADD:  y_o = a_i + b_i;
            ALU_AND:  y_o = a_i & b_i;
            ALU_OR:   y_o = a_i | b_i;
            ALU_NOR:  y_o = ~(a_i | b_i);
            ALU_SHL:  y_o = b_i << sh_i;
            ALU_SHR:  y_o = b_i >> sh_i;
            ALU_LESS: y_o = {{(WORD_W-1){1'b0}}, less};
            ALU_HIGH: y_o = b_i;
            default:  y_o = '0;
        endcase
    end

endmodule

// File: rtl/exec_stage.sv
module exec_stage
    import exec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       instr_i,
    input  logic [31:0]       rs_val_i,
    input  logic [31:0]       rt_val_i,
    output logic [31:0]       result_o,
    output logic [4:0]        dst_o,
    output logic              wr_en_o
);

    localparam int N_SRC = 2;

    ctrl_t              ctrl;
    logic [REG_AW-1:0]  idx   [N_SRC];
    logic [WORD_W-1:0]  vals  [N_SRC];
    logic [WORD_W-1:0]  opa;
    logic [WORD_W-1:0]  opb;
    logic [WORD_W-1:0]  rt_eff;
    logic [WORD_W-1:0]  alu_y;
    logic [REG_AW-1:0]  dst_sel;
    stage_t             stage_d;
    stage_t             stage_q;

    assign idx[0]  = instr_i[RS_LSB +: REG_AW];
    assign idx[1]  = instr_i[RT_LSB +: REG_AW];
    assign vals[0] = rs_val_i;
    assign vals[1] = rt_val_i;

    exec_decode u_decode (
        .op_i   (instr_i[OP_LSB +: OP_W]),
        .fn_i   (instr_i[FN_W-1:0]),
        .ctrl_o (ctrl)
    );

    exec_operand #(.N_SRC(N_SRC)) u_operand (
        .idx_i  (idx),
        .val_i  (vals),
        .imm_i  (instr_i[IMM_W-1:0]),
        .ctrl_i (ctrl),
        .a_o    (opa),
        .b_o    (opb),
        .rt_o   (rt_eff)
    );

    exec_alu u_alu (
        .op_i (ctrl.op),
        .a_i  (opa),
        .b_i  ((ctrl.op == ALU_SHL || ctrl.op == ALU_SHR) ? rt_eff : opb),
        .sh_i (instr_i[SH_LSB +: SH_W]),
        .y_o  (alu_y)
    );

    always_comb begin
        dst_sel = ctrl.dst_from_rd ? instr_i[RD_LSB +: REG_AW]
                                   : instr_i[RT_LSB +: REG_AW];
        stage_d = '0;
        if (ctrl.legal) begin
            stage_d.result = alu_y;
            stage_d.dst    = dst_sel;
            stage_d.wr_en  = (dst_sel != '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign result_o = stage_q.result;
    assign dst_o    = stage_q.dst;
    assign wr_en_o  = stage_q.wr_en;

endmodule

// File: rtl/exec_stage_chk.sv
module exec_stage_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] instr_i,
    input logic [31:0] rs_val_i,
    input logic [31:0] rt_val_i,
    input logic [31:0] result_o,
    input logic [4:0]  dst_o,
    input logic        wr_en_o
);

    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (result_o == 32'd0 && dst_o == 5'd0 && !wr_en_o));

    assert_shift_left_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(instr_i[31:26] == 6'h00 && instr_i[5:0] == 6'd0))
        |-> result_o == ($past(instr_i[20:16] == 5'd0) ? 32'd0
                         : ($past(rt_val_i) << $past(instr_i[10:6]))));

    assert_less_is_bool_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(instr_i[31:26] == 6'h0A)) |-> result_o[31:1] == 31'd0);

    assert_upper_place_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(instr_i[31:26] == 6'h0F))
        |-> (result_o[15:0] == 16'd0 && result_o[31:16] == $past(instr_i[15:0])));

    assert_zero_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(instr_i[31:26] == 6'h0D && instr_i[25:21] == 5'd0))
        |-> result_o == {16'd0, $past(instr_i[15:0])});

    assert_no_zero_dest_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> dst_o != 5'd0);

    assert_const_dest_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(instr_i[31:26] == 6'h08)) |-> dst_o == $past(instr_i[20:16]));

    assert_unknown_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(instr_i[31:26] == 6'h3F))
        |-> (result_o == 32'd0 && dst_o == 5'd0 && !wr_en_o));

    // The first source value does not reach a shift result.
    assert_shift_ignores_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(instr_i[31:26] == 6'h00 && instr_i[5:0] == 6'd2 && instr_i[20:16] == 5'd0))
        |-> result_o == 32'd0);

endmodule

bind exec_stage exec_stage_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .instr_i  (instr_i),
    .rs_val_i (rs_val_i),
    .rt_val_i (rt_val_i),
    .result_o (result_o),
    .dst_o    (dst_o),
    .wr_en_o  (wr_en_o)
);

// File: tb/exec_stage_tb.sv
`timescale 1ns/1ps
module exec_stage_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rs_v = '0;
    logic [31:0] rt_v = '0;
    logic [31:0] result;
    logic [4:0]  dst;
    logic        wr_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [31:0] exp_res_q [$];
    logic [4:0]  exp_dst_q [$];
    logic        exp_we_q  [$];
    string       tag_q     [$];

    always #2 clk = ~clk;

    exec_stage u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .instr_i  (instr),
        .rs_val_i (rs_v),
        .rt_val_i (rt_v),
        .result_o (result),
        .dst_o    (dst),
        .wr_en_o  (wr_en)
    );

    function automatic logic [31:0] rfmt(input int s, input int t, input int d,
                                         input int sh, input int fn);
        rfmt = {6'h00, s[4:0], t[4:0], d[4:0], sh[4:0], fn[5:0]};
    endfunction

    function automatic logic [31:0] kfmt(input int op, input int s, input int t,
                                         input logic [15:0] k);
        kfmt = {op[5:0], s[4:0], t[4:0], k};
    endfunction

    // Reference model written from the requirements.
    task automatic model(input logic [31:0] ins, input logic [31:0] a_in,
                         input logic [31:0] b_in, output logic [31:0] r,
                         output logic [4:0] d, output logic w);
        logic [31:0] a, b, sx, zx;
        logic        ok;
        a  = (ins[25:21] == 0) ? 32'd0 : a_in;
        b  = (ins[20:16] == 0) ? 32'd0 : b_in;
        sx = {{16{ins[15]}}, ins[15:0]};
        zx = {16'd0, ins[15:0]};
        ok = 1'b1;
        r  = 32'd0;
        d  = ins[20:16];
        case (ins[31:26])
            6'h00: begin
                d = ins[15:11];
                case (ins[5:0])
                    6'd32: r = a + b;
                    6'd36: r = a & b;
                    6'd37: r = a | b;
                    6'd39: r = ~(a | b);
                    6'd0:  r = b << ins[10:6];
                    6'd2:  r = b >> ins[10:6];
                    default: ok = 1'b0;
                endcase
            end
            6'h08: r = a + sx;
            6'h0A: r = ($signed(a) < $signed(sx)) ? 32'd1 : 32'd0;
            6'h0C: r = a & zx;
            6'h0D: r = a | zx;
            6'h0F: r = {ins[15:0], 16'd0};
            default: ok = 1'b0;
        endcase
        if (!ok) begin
            r = 32'd0;
            d = 5'd0;
        end
        w = ok && (d != 5'd0);
    endtask

    task automatic drive(input logic [31:0] ins, input logic [31:0] a,
                         input logic [31:0] b, input string tag);
        logic [31:0] r;
        logic [4:0]  d;
        logic        w;
        @(negedge clk);
        instr = ins;
        rs_v  = a;
        rt_v  = b;
        model(ins, a, b, r, d, w);
        exp_res_q.push_back(r);
        exp_dst_q.push_back(d);
        exp_we_q.push_back(w);
        tag_q.push_back(tag);
    endtask

    // Monitor: outputs settle after the rising edge that captured the item.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && exp_res_q.size() > 0) begin
                logic [31:0] er;
                logic [4:0]  ed;
                logic        ew;
                string       tg;
                er = exp_res_q.pop_front();
                ed = exp_dst_q.pop_front();
                ew = exp_we_q.pop_front();
                tg = tag_q.pop_front();
                n_checks++;
                if (result !== er || dst !== ed || wr_en !== ew) begin
                    n_fail++;
                    $display("FAIL %s: got res=%h dst=%0d we=%b, expected res=%h dst=%0d we=%b",
                             tg, result, dst, wr_en, er, ed, ew);
                end
            end
        end
    end

    initial begin
        #100000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // R1: outputs held at zero while reset is low, even with live inputs.
        instr = rfmt(17, 18, 8, 0, 32);
        rs_v  = 32'd5;
        rt_v  = 32'd6;
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_checks++;
        if (result !== 32'd0 || dst !== 5'd0 || wr_en !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset: got res=%h dst=%0d we=%b, expected 0/0/0", result, dst, wr_en);
        end
        rst_n = 1'b1;

        drive(rfmt(17, 18, 8, 0, 32), 32'd1000, 32'd234, "R2 add");
        drive(rfmt(1, 2, 3, 0, 32), 32'hFFFF_FFFF, 32'd1, "R2 add wrap");
        drive(rfmt(9, 10, 8, 5, 36), 32'h0000_0DC0, 32'h0000_3C00, "R3 and");
        drive(rfmt(9, 10, 8, 0, 37), 32'h0000_0DC0, 32'h0000_3C00, "R3 or");
        drive(rfmt(9, 10, 8, 0, 39), 32'h0F0F_0000, 32'h0000_3C00, "R3 nor");
        drive(rfmt(9, 0, 8, 0, 39), 32'h0000_3C00, 32'hFFFF_FFFF, "R3 nor as not");
        drive(rfmt(0, 16, 10, 8, 0), 32'h1234_5678, 32'h8000_00FF, "R4 shl 8");
        drive(rfmt(0, 16, 10, 8, 2), 32'h1234_5678, 32'h8000_00FF, "R4 shr 8");
        drive(rfmt(0, 16, 10, 31, 0), 32'd0, 32'hFFFF_FFFF, "R4 shl 31");
        drive(rfmt(0, 16, 10, 31, 2), 32'd0, 32'hFFFF_FFFF, "R4 shr 31");
        drive(rfmt(4, 16, 10, 0, 2), 32'hAAAA_AAAA, 32'hDEAD_BEEF, "R4 shr 0");
        drive(kfmt(8, 29, 29, 16'hFFFC), 32'd100, 32'd0, "R5 add neg const");
        drive(kfmt(8, 29, 29, 16'h8000), 32'd0, 32'd0, "R5 add min const");
        drive(kfmt(8, 5, 6, 16'h7FFF), 32'd1, 32'd0, "R5 add pos const");
        drive(kfmt(12, 5, 6, 16'hFFFF), 32'hFFFF_FFFF, 32'd0, "R6 and zext");
        drive(kfmt(13, 5, 6, 16'h8001), 32'h0F00_0000, 32'd0, "R6 or zext");
        drive(kfmt(10, 18, 8, 16'd15), 32'hFFFF_FFFB, 32'd0, "R7 less neg");
        drive(kfmt(10, 18, 8, 16'd15), 32'd20, 32'd0, "R7 not less");
        drive(kfmt(10, 18, 8, 16'hFFFF), 32'h7FFF_FFFF, 32'd0, "R7 max vs -1");
        drive(kfmt(10, 18, 8, 16'h7FFF), 32'h8000_0000, 32'd0, "R7 min vs pos");
        drive(kfmt(10, 18, 8, 16'd15), 32'd15, 32'd0, "R7 equal");
        drive(kfmt(15, 7, 8, 16'hAAAA), 32'hFFFF_FFFF, 32'd0, "R8 upper");
        drive(kfmt(13, 8, 8, 16'hAAAA), 32'hAAAA_0000, 32'd0, "R8 upper then or");
        drive(rfmt(0, 0, 8, 0, 32), 32'h1111_1111, 32'h2222_2222, "R9 both zero idx");
        drive(kfmt(13, 0, 9, 16'h0042), 32'hFFFF_FFFF, 32'd0, "R9 zero idx const");
        drive(rfmt(0, 0, 8, 4, 0), 32'd7, 32'hFFFF_FFFF, "R9 zero idx shift");
        drive(rfmt(3, 4, 0, 0, 32), 32'd1, 32'd2, "R10 reg dst zero");
        drive(kfmt(8, 3, 0, 16'd1), 32'd1, 32'd0, "R10 const dst zero");
        drive(kfmt(8, 3, 31, 16'd1), 32'd1, 32'd0, "R10 const dst rt");
        drive(kfmt(6'h3F, 3, 4, 16'h1234), 32'd9, 32'd9, "R11 bad opcode");
        drive(rfmt(3, 4, 5, 0, 1), 32'd9, 32'd9, "R11 bad funct");
        drive(kfmt(6'h23, 3, 4, 16'h0004), 32'd9, 32'd9, "R11 unsupported load");
        drive(rfmt(17, 18, 8, 0, 32), 32'd3, 32'd4, "R1 recovery");

        @(negedge clk);
        @(negedge clk);
        if (exp_res_q.size() != 0) begin
            n_checks++;
            n_fail++;
            $display("FAIL R1 drain: got %0d pending, expected 0", exp_res_q.size());
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule